// File: doc/BRIEF.md
# Host Parallel Command/Data Port

This block is the slave side of an 8-bit parallel port through which an external microcontroller trades commands and data bytes with an on-chip processor. The host drives an active-low chip select, write strobe and read strobe. A select line marks each transfer as command traffic (low) or data traffic (high). The host strobes have no fixed relation to the core clock. They pass through a synchroniser, and writes and reads are acted on when their strobe rises.

On the core side there are four single-entry holding registers, each with a valid/ready pair. Command and data bytes written by the host land in two inbound registers. The processor fills two outbound registers that the host reads back. Two active-low handshake outputs tell the host what to do. `reqN` asks the host to fetch a waiting command. `rdyN` says whether the host may send another data byte. The pad's output enable comes from the raw chip-select and read pins, so the bus turns around without waiting for the synchroniser. A mode pin picks the standard interface (0, the default). Any other mode leaves the port idle.

Top module: `hppTop`

## Requirements
- R1: After reset, `cmdInValid`, `dataInValid`, `overflow`, `busOe` and `rdyN` are 0, `reqN` is 1, and `cmdOutReady` and `dataOutReady` are 1.
- R2: With `modeSel`=0 and `csN` low, a rising `wrN` while `cmdDataSel`=0 places the byte the host held on `busIn` in the command-in register and raises `cmdInValid`. The byte stays valid until `cmdInReady` consumes it.
- R3: A data write (`cmdDataSel`=1) is latched into the data-in register and raises `dataInValid`. From then on `rdyN` is high, and it returns low only after `dataInReady` consumes the byte.
- R4: A write strobe given while `csN` is high changes no register and no output.
- R5: A host write aimed at a full inbound register is dropped, so the held byte is unchanged. It sets `overflow`, which stays set until reset.
- R6: Loading the command-out register (`cmdOutValid` while `cmdOutReady`) drives `reqN` low and `cmdOutReady` low. A host read with `cmdDataSel`=0 returns that byte on `busOut`. Its rising `rdN` then frees the register: `reqN` and `cmdOutReady` return high.
- R7: A host read with `cmdDataSel`=1 returns the data-out byte. Its rising `rdN` frees the data-out register and raises `dataOutReady`.
- R8: `busOe` is 1 exactly while `csN`=0, `rdN`=0 and `modeSel`=0. The bus is released at all other times.
- R9: With `modeSel`=1, host writes and reads have no effect on any register, and `busOe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | 8 | Host bus value seen at the pad |
| busOut | output | 8 | Byte offered to the host during a read |
| busOe | output | 1 | Pad output enable, 1 drives the bus |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| cmdDataSel | input | 1 | 1 selects data, 0 selects command |
| modeSel | input | 1 | 0 selects the standard parallel interface |
| reqN | output | 1 | Low while a command waits for the host |
| rdyN | output | 1 | Low while the host may send a data byte |
| cmdInValid | output | 1 | Command-in register holds a byte |
| cmdInData | output | 8 | Command-in byte |
| cmdInReady | input | 1 | Core consumes the command-in byte |
| dataInValid | output | 1 | Data-in register holds a byte |
| dataInData | output | 8 | Data-in byte |
| dataInReady | input | 1 | Core consumes the data-in byte |
| cmdOutValid | input | 1 | Core offers a command byte |
| cmdOutData | input | 8 | Command byte for the host |
| cmdOutReady | output | 1 | Command-out register is empty |
| dataOutValid | input | 1 | Core offers a data byte |
| dataOutData | input | 8 | Data byte for the host |
| dataOutReady | output | 1 | Data-out register is empty |
| overflow | output | 1 | Sticky flag for a dropped host write |

## Verification
The bench goes after these corner cases:
- Writes into a full inbound register: a design that let them through would overwrite the held byte and leave `overflow` clear.
- Back-to-back writes: a design that sampled the bus after the strobe rose would capture the next byte the host had already put on the bus.
- Reads of empty outbound registers: a design that freed a register on the wrong select would lose the other register's byte and release `reqN` early.
- Strobes given with chip select high or with the alternate mode pin set: a careless design would latch these or drive the bus.

// File: rtl/hppPkg.sv
package hppPkg;
  parameter int BYTE_W = 8;

  // strobes from the control unit to the datapath, each one cycle wide
  typedef struct packed {
    logic ldCmdIn;
    logic ldDataIn;
    logic clrCmdOut;
    logic clrDataOut;
    logic setOvf;
  } hppStrobe_t;
endpackage

// File: rtl/hppCtrl.sv
module hppCtrl
  import hppPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wrN,
  input  logic       rdN,
  input  logic       cmdDataSel,
  input  logic       modeSel,
  input  logic       cmdInFull,
  input  logic       dataInFull,
  input  logic       cmdInTake,
  input  logic       dataInTake,
  output hppStrobe_t strobe
);
  // bit order of the synchronised control vector
  localparam int CTL_W  = 4;
  localparam int IDX_CS = 0;
  localparam int IDX_WR = 1;
  localparam int IDX_RD = 2;
  localparam int IDX_SL = 3;

  logic [CTL_W-1:0] ctlRaw;
  logic [CTL_W-1:0] ctlSync [SYNC_STAGES];
  logic [CTL_W-1:0] ctlDly;
  logic [CTL_W-1:0] ctlNow;

  assign ctlRaw = {cmdDataSel, rdN, wrN, csN};

  // idle pins: strobes and select high, data select low
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b0111;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ctlSync[g] <= CTL_IDLE;
        else if (g == 0) ctlSync[g] <= ctlRaw;
        else ctlSync[g] <= ctlSync[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ctlNow = ctlSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlDly <= CTL_IDLE;
    else ctlDly <= ctlNow;
  end

  logic selected;
  logic wrRise;
  logic rdRise;
  logic wantCmd;
  logic wantData;
  logic cmdRoom;
  logic dataRoom;

  // chip select and data select are taken from the stage where the strobe was still low
  assign selected = ~ctlDly[IDX_CS] & ~modeSel;
  assign wrRise   = ctlNow[IDX_WR] & ~ctlDly[IDX_WR] & selected;
  assign rdRise   = ctlNow[IDX_RD] & ~ctlDly[IDX_RD] & selected;
  assign wantCmd  = wrRise & ~ctlDly[IDX_SL];
  assign wantData = wrRise &  ctlDly[IDX_SL];
  assign cmdRoom  = ~cmdInFull  | cmdInTake;
  assign dataRoom = ~dataInFull | dataInTake;

  always_comb begin
    strobe            = '0;
    strobe.ldCmdIn    = wantCmd & cmdRoom;
    strobe.ldDataIn   = wantData & dataRoom;
    strobe.setOvf     = (wantCmd & ~cmdRoom) | (wantData & ~dataRoom);
    strobe.clrCmdOut  = rdRise & ~ctlDly[IDX_SL];
    strobe.clrDataOut = rdRise &  ctlDly[IDX_SL];
  end
endmodule

// File: rtl/hppDatapath.sv
module hppDatapath
  import hppPkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hppStrobe_t        strobe,
  input  logic [DATA_W-1:0] busIn,
  input  logic              csN,
  input  logic              rdN,
  input  logic              cmdDataSel,
  input  logic              modeSel,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              cmdInReady,
  input  logic              dataInReady,
  input  logic              cmdOutValid,
  input  logic [DATA_W-1:0] cmdOutData,
  input  logic              dataOutValid,
  input  logic [DATA_W-1:0] dataOutData,
  output logic              cmdInFull,
  output logic              dataInFull,
  output logic [DATA_W-1:0] cmdInByte,
  output logic [DATA_W-1:0] dataInByte,
  output logic              cmdOutFull,
  output logic              dataOutFull,
  output logic              ovfFlag
);
  // the bus is delayed one stage more than the strobes reach the edge detector
  localparam int BUS_STAGES = SYNC_STAGES + 1;

  logic [DATA_W-1:0] busPipe [BUS_STAGES];

  genvar g;
  generate
    for (g = 0; g < BUS_STAGES; g++) begin : gBus
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busPipe[g] <= '0;
        else if (g == 0) busPipe[g] <= busIn;
        else busPipe[g] <= busPipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  logic [DATA_W-1:0] busHeld;
  assign busHeld = busPipe[BUS_STAGES-1];

  logic [DATA_W-1:0] cmdOutByte;
  logic [DATA_W-1:0] dataOutByte;

  // inbound registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdInFull  <= 1'b0;
      cmdInByte  <= '0;
      dataInFull <= 1'b0;
      dataInByte <= '0;
    end else begin
      if (strobe.ldCmdIn) begin
        cmdInFull <= 1'b1;
        cmdInByte <= busHeld;
      end else if (cmdInReady) begin
        cmdInFull <= 1'b0;
      end
      if (strobe.ldDataIn) begin
        dataInFull <= 1'b1;
        dataInByte <= busHeld;
      end else if (dataInReady) begin
        dataInFull <= 1'b0;
      end
    end
  end

  // outbound registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOutFull  <= 1'b0;
      cmdOutByte  <= '0;
      dataOutFull <= 1'b0;
      dataOutByte <= '0;
    end else begin
      if (cmdOutValid && !cmdOutFull) begin
        cmdOutFull <= 1'b1;
        cmdOutByte <= cmdOutData;
      end else if (strobe.clrCmdOut) begin
        cmdOutFull <= 1'b0;
      end
      if (dataOutValid && !dataOutFull) begin
        dataOutFull <= 1'b1;
        dataOutByte <= dataOutData;
      end else if (strobe.clrDataOut) begin
        dataOutFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (strobe.setOvf) ovfFlag <= 1'b1;
  end

  // the pad turns around straight from the pins
  assign busOe  = ~csN & ~rdN & ~modeSel;
  assign busOut = cmdDataSel ? dataOutByte : cmdOutByte;
endmodule

// File: rtl/hppTop.sv
module hppTop
  import hppPkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              cmdDataSel,
  input  logic              modeSel,
  output logic              reqN,
  output logic              rdyN,
  output logic              cmdInValid,
  output logic [DATA_W-1:0] cmdInData,
  input  logic              cmdInReady,
  output logic              dataInValid,
  output logic [DATA_W-1:0] dataInData,
  input  logic              dataInReady,
  input  logic              cmdOutValid,
  input  logic [DATA_W-1:0] cmdOutData,
  output logic              cmdOutReady,
  input  logic              dataOutValid,
  input  logic [DATA_W-1:0] dataOutData,
  output logic              dataOutReady,
  output logic              overflow
);
  hppStrobe_t strobe;
  logic cmdInFull, dataInFull, cmdOutFull, dataOutFull;

  hppCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .wrN        (wrN),
    .rdN        (rdN),
    .cmdDataSel (cmdDataSel),
    .modeSel    (modeSel),
    .cmdInFull  (cmdInFull),
    .dataInFull (dataInFull),
    .cmdInTake  (cmdInReady),
    .dataInTake (dataInReady),
    .strobe     (strobe)
  );

  hppDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busIn        (busIn),
    .csN          (csN),
    .rdN          (rdN),
    .cmdDataSel   (cmdDataSel),
    .modeSel      (modeSel),
    .busOut       (busOut),
    .busOe        (busOe),
    .cmdInReady   (cmdInReady),
    .dataInReady  (dataInReady),
    .cmdOutValid  (cmdOutValid),
    .cmdOutData   (cmdOutData),
    .dataOutValid (dataOutValid),
    .dataOutData  (dataOutData),
    .cmdInFull    (cmdInFull),
    .dataInFull   (dataInFull),
    .cmdInByte    (cmdInData),
    .dataInByte   (dataInData),
    .cmdOutFull   (cmdOutFull),
    .dataOutFull  (dataOutFull),
    .ovfFlag      (overflow)
  );

  assign cmdInValid   = cmdInFull;
  assign dataInValid  = dataInFull;
  assign cmdOutReady  = ~cmdOutFull;
  assign dataOutReady = ~dataOutFull;
  assign reqN         = ~cmdOutFull;
  assign rdyN         = dataInFull;
endmodule

// File: rtl/hppChecker.sv
module hppChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              modeSel,
  input logic              busOe,
  input logic              reqN,
  input logic              rdyN,
  input logic              cmdInValid,
  input logic [DATA_W-1:0] cmdInData,
  input logic              cmdInReady,
  input logic              dataInValid,
  input logic              dataInReady,
  input logic              cmdOutValid,
  input logic              cmdOutReady,
  input logic              overflow
);
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN || modeSel) |-> !busOe); // R8

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInValid && !cmdInReady) |=> (cmdInValid && $stable(cmdInData))); // R2

  AST_RDY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    dataInValid |-> rdyN); // R3

  AST_RDY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (dataInValid && dataInReady) |=> (!rdyN || dataInValid)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R5

  AST_REQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOutValid && cmdOutReady) |=> (!reqN && !cmdOutReady)); // R6
endmodule

bind hppTop hppChecker #(.DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (csN),
  .rdN         (rdN),
  .modeSel     (modeSel),
  .busOe       (busOe),
  .reqN        (reqN),
  .rdyN        (rdyN),
  .cmdInValid  (cmdInValid),
  .cmdInData   (cmdInData),
  .cmdInReady  (cmdInReady),
  .dataInValid (dataInValid),
  .dataInReady (dataInReady),
  .cmdOutValid (cmdOutValid),
  .cmdOutReady (cmdOutReady),
  .overflow    (overflow)
);

// File: tb/hppTop_test.sv
module hppTop_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic busOe;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, cmdDataSel = 1'b0, modeSel = 1'b0;
  logic reqN, rdyN;
  logic cmdInValid, dataInValid, cmdOutReady, dataOutReady, overflow;
  logic [7:0] cmdInData, dataInData;
  logic cmdInReady = 1'b0, dataInReady = 1'b0;
  logic cmdOutValid = 1'b0, dataOutValid = 1'b0;
  logic [7:0] cmdOutData = '0, dataOutData = '0;

  int total = 0;
  int bad = 0;

  // bench model of the port
  bit mCmdInFull, mDataInFull, mCmdOutFull, mDataOutFull, mOvf;
  logic [7:0] mCmdIn, mDataIn, mCmdOut, mDataOut;

  always #2 clk = ~clk;

  hppTop uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(bit sel);
    return sel ? mDataOut : mCmdOut;
  endfunction

  task automatic checkAll(string req);
    chk({req, " cmdInValid"}, cmdInValid, mCmdInFull);
    if (mCmdInFull) chk({req, " cmdInData"}, cmdInData, mCmdIn);
    chk({req, " dataInValid"}, dataInValid, mDataInFull);
    if (mDataInFull) chk({req, " dataInData"}, dataInData, mDataIn);
    chk({req, " rdyN"}, rdyN, mDataInFull);
    chk({req, " reqN"}, reqN, !mCmdOutFull);
    chk({req, " cmdOutReady"}, cmdOutReady, !mCmdOutFull);
    chk({req, " dataOutReady"}, dataOutReady, !mDataOutFull);
    chk({req, " overflow"}, overflow, mOvf);
    chk({req, " busOe idle"}, busOe, 0);
  endtask

  task automatic hostWrite(bit sel, logic [7:0] val, bit useCs);
    busIn = val; cmdDataSel = sel; csN = !useCs;
    waitClk(2); wrN = 1'b0;
    waitClk(4); wrN = 1'b1;
    waitClk(5); csN = 1'b1;
    busIn = ~val;  // next byte appears right away
    waitClk(3);
    if (useCs && !modeSel) begin
      if (sel) begin
        if (mDataInFull) mOvf = 1; else begin mDataInFull = 1; mDataIn = val; end
      end else begin
        if (mCmdInFull) mOvf = 1; else begin mCmdInFull = 1; mCmdIn = val; end
      end
    end
  endtask

  task automatic hostRead(bit sel, string req);
    cmdDataSel = sel; csN = 1'b0;
    waitClk(1); rdN = 1'b0;
    waitClk(3);
    chk({req, " busOe read"}, busOe, !modeSel);   // R8
    if (!modeSel) chk({req, " busOut"}, busOut, expRead(sel));
    rdN = 1'b1;
    waitClk(5); csN = 1'b1;
    waitClk(3);
    if (!modeSel) begin
      if (sel) mDataOutFull = 0; else mCmdOutFull = 0;
    end
  endtask

  task automatic takeCmd();
    cmdInReady = 1'b1; waitClk(1); cmdInReady = 1'b0; waitClk(1);
    mCmdInFull = 0;
  endtask

  task automatic takeData();
    dataInReady = 1'b1; waitClk(1); dataInReady = 1'b0; waitClk(1);
    mDataInFull = 0;
  endtask

  task automatic loadCmd(logic [7:0] v);
    cmdOutData = v; cmdOutValid = 1'b1; waitClk(1); cmdOutValid = 1'b0; waitClk(1);
    if (!mCmdOutFull) begin mCmdOutFull = 1; mCmdOut = v; end
  endtask

  task automatic loadData(logic [7:0] v);
    dataOutData = v; dataOutValid = 1'b1; waitClk(1); dataOutValid = 1'b0; waitClk(1);
    if (!mDataOutFull) begin mDataOutFull = 1; mDataOut = v; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5A17));
    mCmdIn = '0; mDataIn = '0; mCmdOut = '0; mDataOut = '0;
    waitClk(3); rstN = 1'b1; waitClk(2);
    checkAll("R1 reset");

    // directed: command and data writes
    hostWrite(0, 8'h3C, 1); checkAll("R2 cmd write");
    hostWrite(1, 8'hA5, 1); checkAll("R3 data write rdyN high");
    takeData(); checkAll("R3 data take rdyN low");
    takeCmd(); checkAll("R2 cmd take");

    // write with chip select high
    hostWrite(0, 8'h77, 0); checkAll("R4 cs high");

    // overflow on both registers
    hostWrite(1, 8'h11, 1);
    hostWrite(1, 8'h22, 1); checkAll("R5 data overflow");
    takeData(); checkAll("R5 overflow sticky");
    hostWrite(0, 8'h33, 1);
    hostWrite(0, 8'h44, 1); checkAll("R5 cmd overflow");
    takeCmd();

    // outbound paths
    loadCmd(8'hC3); checkAll("R6 reqN low");
    hostRead(1, "R7 wrong select keeps cmd"); checkAll("R6 cmd kept");
    hostRead(0, "R6 cmd read"); checkAll("R6 reqN released");
    loadData(8'h5E); checkAll("R7 load");
    hostRead(1, "R7 data read"); checkAll("R7 freed");

    // alternate mode ignores everything
    loadCmd(8'h99);
    modeSel = 1'b1; waitClk(4);
    hostWrite(1, 8'hEE, 1);
    hostRead(0, "R9 mode read"); checkAll("R9 mode ignored");
    modeSel = 1'b0; waitClk(4);
    hostRead(0, "R6 after mode"); checkAll("R9 back to standard");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 7);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: hostWrite(0, v, 1);
        1: hostWrite(1, v, 1);
        2: hostRead(0, "R6 random read");
        3: hostRead(1, "R7 random read");
        4: takeCmd();
        5: takeData();
        6: loadCmd(v);
        default: loadData(v);
      endcase
      checkAll("R2 R3 R5 R6 R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule